// File: doc/BRIEF.md
# 16-bit Host to 8-bit NAND Bus Bridge

This block sits between a 16-bit register bus on the host side and an 8-bit NAND flash device. Software programs a mode register to choose the power state of the flash and whether byte cycles carry data, a command, or an address. The command-latch and address-latch strobes come straight from two bits of that register. Every host access to the data port turns into two NAND byte cycles. A write sends its low byte first and then its high byte. A read builds a 16-bit word from two byte reads, with the first byte in the low half.

The host bus works as a request and wait handshake. The host holds `hst_sel` and keeps its address and data stable until it sees `hst_ready` high at a rising clock edge. Register accesses finish in the cycle they are presented. A data-port access in the active state stalls the host until both byte cycles are over. The NAND ready/busy line is synchronised and shown as a busy flag. Its edges set sticky interrupt status bits. Software clears these bits by writing ones, and a mask register gates them onto a single interrupt line.

Register map (word addresses on `hst_addr`): 0 data port, 1 mode, 2 status, 3 interrupt status, 4 interrupt mask. Any other address reads as zero.

Top module: `nand16_bridge`

## Requirements
- R1: After reset the mode register reads 0x00 (power off), the interrupt mask and interrupt status read 0, `nd_ce_n`, `nd_we_n` and `nd_re_n` are 1, `nd_pwr_en` is 0 and `irq` is 0.
- R2: A data-port write in the active state produces exactly two `nd_we_n` pulses. At the first rising edge `nd_dout` holds `hst_wdata[7:0]`, and at the second it holds `hst_wdata[15:8]`.
- R3: A data-port read in the active state produces exactly two `nd_re_n` pulses. It returns the first byte in bits 7..0 and the second byte in bits 15..8, and `nd_doe` is 0 while `nd_re_n` is low.
- R4: An active-state data access raises `hst_ready` exactly 4*STROBE_CYC+1 cycles after it is presented, for one cycle. Accesses to any other register, or to the data port outside the active state, see `hst_ready` in the cycle they are presented.
- R5: The mode byte holds command-latch enable in bit 0, address-latch enable in bit 1 and the power state in bits 3..2 (00 off, 01 standby, 10 on, 11 active). `nd_cle` and `nd_ale` follow bits 0 and 1 while the state is active: 0x0C is data, 0x0D is command and 0x0E is address.
- R6: Outside the active state `nd_ce_n` is 1, data-port accesses produce no strobe pulses and return 0. `nd_pwr_en` is 1 in every state except off.
- R7: Status bit 0 reads 1 while `nd_rb` is low (busy). It follows the pin two clock edges after the pin changes.
- R8: A busy-to-ready transition of `nd_rb` sets interrupt status bit 0, and a ready-to-busy transition sets bit 1. Bits 3..2 stay 0.
- R9: Writing the interrupt status register clears each bit written as 1. Writing 0x0F clears all four bits, and bits written as 0 are unchanged.
- R10: `irq` equals mask bit 7 ANDed with the OR over bits 3..0 of (status AND mask). Writing 0x81 enables only the ready interrupt, and writing 0x00 disables all interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 1 | Host access request, held until ready |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W | Register word address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid when ready |
| hst_ready | output | 1 | Access completes at this rising edge |
| nd_din | input | 8 | Byte from the flash |
| nd_dout | output | 8 | Byte to the flash |
| nd_doe | output | 1 | Output enable for nd_dout |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_ce_n | output | 1 | Chip enable, active low |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_rb | input | 1 | Ready/busy line, 0 = busy |
| nd_pwr_en | output | 1 | Flash supply enable |
| irq | output | 1 | Masked interrupt request |

## Verification
Register reads and writes, and data-port accesses outside the active state, are due in the cycle they are presented. The bench therefore samples `hst_ready` and `hst_rdata` one time unit after the negative edge where it drives them, and expects zero wait cycles. An active data access is due after 4*STROBE_CYC+1 rising edges, which is nine with the default. The bench counts negative edges until ready and compares the count. The busy flag is checked one edge after a pin change (still old) and two edges after (new). Interrupt status and `irq` are checked only after several more edges, so that synchroniser and edge-detector latency is covered.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

    // Register word addresses
    localparam int RA_DATA  = 0;
    localparam int RA_MODE  = 1;
    localparam int RA_STAT  = 2;
    localparam int RA_ISTAT = 3;
    localparam int RA_IMASK = 4;

    // Power state field of the mode byte, bits 3..2
    typedef enum logic [1:0] {
        PW_OFF  = 2'b00,
        PW_STBY = 2'b01,
        PW_ON   = 2'b10,
        PW_ACT  = 2'b11
    } pwr_e;

    typedef struct packed {
        logic [3:0] rsv;
        pwr_e       pst;
        logic       ale;
        logic       cle;
    } mode_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LO0,
        SQ_HI0,
        SQ_LO1,
        SQ_HI1,
        SQ_DONE
    } seq_e;

    function automatic seq_e seq_next(input seq_e s);
        case (s)
            SQ_LO0:  return SQ_HI0;
            SQ_HI0:  return SQ_LO1;
            SQ_LO1:  return SQ_HI1;
            SQ_HI1:  return SQ_DONE;
            default: return SQ_IDLE;
        endcase
    endfunction

    function automatic logic seq_upper(input seq_e s);
        return (s == SQ_LO1) || (s == SQ_HI1);
    endfunction

endpackage

// File: rtl/nbb_regs.sv
module nbb_regs
    import nbb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_mode,
    input  logic       wr_istat,
    input  logic       wr_imask,
    input  logic [7:0] wbyte,
    input  logic       rb_pin,
    output mode_t      mode_q,
    output logic [7:0] imask_q,
    output logic [3:0] istat_q,
    output logic       busy,
    output logic       irq
);
    logic       rb_s1, rb_s2, rb_s3;
    logic       rb_rise, rb_fall;
    logic [3:0] set_v, clr_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_s1 <= 1'b1;
            rb_s2 <= 1'b1;
            rb_s3 <= 1'b1;
        end else begin
            rb_s1 <= rb_pin;
            rb_s2 <= rb_s1;
            rb_s3 <= rb_s2;
        end
    end

    assign rb_rise = rb_s2 & ~rb_s3;
    assign rb_fall = ~rb_s2 & rb_s3;
    assign set_v   = {2'b00, rb_fall, rb_rise};
    assign clr_v   = wr_istat ? wbyte[3:0] : 4'h0;
    assign busy    = ~rb_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            imask_q <= 8'h00;
            istat_q <= 4'h0;
        end else begin
            if (wr_mode)  mode_q  <= mode_t'(wbyte);
            if (wr_imask) imask_q <= wbyte;
            istat_q <= (istat_q & ~clr_v) | set_v;
        end
    end

    assign irq = imask_q[7] & |(istat_q & imask_q[3:0]);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_istat && wbyte[0] && !rb_rise) |=> !istat_q[0]); // R9
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        rb_rise |=> istat_q[0]); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !imask_q[7] |-> !irq); // R10
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        istat_q[3:2] == 2'b00); // R8
endmodule

// File: rtl/nbb_byteseq.sv
module nbb_byteseq
    import nbb_pkg::*;
#(
    parameter int STROBE_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        is_wr,
    input  logic [15:0] wdata,
    input  logic [7:0]  din,
    output logic        we_n,
    output logic        re_n,
    output logic        doe,
    output logic [7:0]  dout,
    output logic [15:0] rdata,
    output logic        done
);
    localparam int CNT_W = $clog2(STROBE_CYC) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

    seq_e             st;
    logic [CNT_W-1:0] cnt;
    logic             wr_q;
    logic [15:0]      wbuf;
    logic [15:0]      rbuf;
    logic             low_ph, busy_ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            cnt  <= '0;
            wr_q <= 1'b0;
            wbuf <= 16'h0;
            rbuf <= 16'h0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st   <= SQ_LO0;
                        cnt  <= '0;
                        wr_q <= is_wr;
                        wbuf <= wdata;
                    end
                end
                SQ_DONE: st <= SQ_IDLE;
                default: begin
                    if (cnt == CNT_LAST) begin
                        cnt <= '0;
                        st  <= seq_next(st);
                        if (!wr_q && st == SQ_LO0) rbuf[7:0]  <= din;
                        if (!wr_q && st == SQ_LO1) rbuf[15:8] <= din;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign low_ph  = (st == SQ_LO0) || (st == SQ_LO1);
    assign busy_ph = (st != SQ_IDLE) && (st != SQ_DONE);
    assign we_n    = ~(low_ph & wr_q);
    assign re_n    = ~(low_ph & ~wr_q);
    assign doe     = busy_ph & wr_q;
    assign dout    = seq_upper(st) ? wbuf[15:8] : wbuf[7:0];
    assign rdata   = rbuf;
    assign done    = (st == SQ_DONE);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4
    AST_START_STROBE: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && start) |=> (!we_n || !re_n)); // R4
endmodule

// File: rtl/nand16_bridge.sv
module nand16_bridge
    import nbb_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int STROBE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_sel,
    input  logic              hst_wr,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [15:0]       hst_wdata,
    output logic [15:0]       hst_rdata,
    output logic              hst_ready,
    input  logic [7:0]        nd_din,
    output logic [7:0]        nd_dout,
    output logic              nd_doe,
    output logic              nd_cle,
    output logic              nd_ale,
    output logic              nd_ce_n,
    output logic              nd_we_n,
    output logic              nd_re_n,
    input  logic              nd_rb,
    output logic              nd_pwr_en,
    output logic              irq
);
    mode_t       mode_q;
    logic [7:0]  imask_q;
    logic [3:0]  istat_q;
    logic        busy;
    logic        act;
    logic        a_data, a_mode, a_stat, a_istat, a_imask;
    logic        data_req, seq_done;
    logic        reg_wr;
    logic [15:0] seq_rdata;

    assign a_data  = (hst_addr == ADDR_W'(RA_DATA));
    assign a_mode  = (hst_addr == ADDR_W'(RA_MODE));
    assign a_stat  = (hst_addr == ADDR_W'(RA_STAT));
    assign a_istat = (hst_addr == ADDR_W'(RA_ISTAT));
    assign a_imask = (hst_addr == ADDR_W'(RA_IMASK));

    assign act      = (mode_q.pst == PW_ACT);
    assign data_req = hst_sel & a_data & act;
    assign hst_ready = data_req ? seq_done : hst_sel;
    assign reg_wr   = hst_sel & hst_wr & ~a_data;

    nbb_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_mode  (reg_wr & a_mode),
        .wr_istat (reg_wr & a_istat),
        .wr_imask (reg_wr & a_imask),
        .wbyte    (hst_wdata[7:0]),
        .rb_pin   (nd_rb),
        .mode_q   (mode_q),
        .imask_q  (imask_q),
        .istat_q  (istat_q),
        .busy     (busy),
        .irq      (irq)
    );

    nbb_byteseq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (data_req),
        .is_wr (hst_wr),
        .wdata (hst_wdata),
        .din   (nd_din),
        .we_n  (nd_we_n),
        .re_n  (nd_re_n),
        .doe   (nd_doe),
        .dout  (nd_dout),
        .rdata (seq_rdata),
        .done  (seq_done)
    );

    always_comb begin
        hst_rdata = 16'h0000;
        if (a_data && act) hst_rdata = seq_rdata;
        if (a_mode)        hst_rdata = {8'h00, mode_q};
        if (a_stat)        hst_rdata = {15'h0, busy};
        if (a_istat)       hst_rdata = {12'h0, istat_q};
        if (a_imask)       hst_rdata = {8'h00, imask_q};
    end

    assign nd_ce_n   = ~act;
    assign nd_cle    = act & mode_q.cle;
    assign nd_ale    = act & mode_q.ale;
    assign nd_pwr_en = (mode_q.pst != PW_OFF);

    AST_CE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!nd_we_n || !nd_re_n) |-> !nd_ce_n); // R6
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !nd_re_n |-> !nd_doe); // R3
    AST_REG_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (hst_sel && !a_data) |-> hst_ready); // R4
endmodule

// File: tb/nand16_bridge_bench.sv
module nand16_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_sel = 1'b0;
    logic        hst_wr = 1'b0;
    logic [2:0]  hst_addr = 3'd0;
    logic [15:0] hst_wdata = 16'h0;
    logic [15:0] hst_rdata;
    logic        hst_ready;
    logic [7:0]  nd_din = 8'h00;
    logic [7:0]  nd_dout;
    logic        nd_doe, nd_cle, nd_ale, nd_ce_n, nd_we_n, nd_re_n;
    logic        nd_rb = 1'b1;
    logic        nd_pwr_en, irq;

    int vectors = 0;
    int fails = 0;
    int wcnt = 0;
    int rd_ptr = 0;
    logic [9:0] wlog [0:15];
    logic [7:0] rd_mem [0:15];
    logic [15:0] rd;
    int waits;

    always #5 clk = ~clk;

    nand16_bridge u_nand16_bridge (
        .clk(clk), .rst(rst), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .hst_ready(hst_ready), .nd_din(nd_din), .nd_dout(nd_dout),
        .nd_doe(nd_doe), .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_ce_n(nd_ce_n),
        .nd_we_n(nd_we_n), .nd_re_n(nd_re_n), .nd_rb(nd_rb),
        .nd_pwr_en(nd_pwr_en), .irq(irq)
    );

    // Flash model: log each written byte, serve read bytes in order
    always @(posedge nd_we_n) begin
        if (!rst && wcnt < 16) begin
            wlog[wcnt] = {nd_cle, nd_ale, nd_dout};
            wcnt++;
        end
    end

    always @(negedge nd_re_n) begin
        if (!rst && rd_ptr < 16) begin
            nd_din = rd_mem[rd_ptr];
            rd_ptr++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [2:0] a, input logic [15:0] d,
                       output logic [15:0] rdo, output int w);
        @(negedge clk);
        hst_sel = 1'b1; hst_wr = wr; hst_addr = a; hst_wdata = d;
        w = 0;
        #1;
        while (!hst_ready) begin
            @(negedge clk);
            #1;
            w++;
        end
        rdo = hst_rdata;
        @(posedge clk);
        #1;
        hst_sel = 1'b0; hst_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ce_n", nd_ce_n, 1);
        chk("R1 we_n", nd_we_n, 1);
        chk("R1 re_n", nd_re_n, 1);
        chk("R1 pwr_en", nd_pwr_en, 0);
        chk("R1 irq", irq, 0);
        bus(0, 3'd1, 16'h0, rd, waits); chk("R1 mode", rd, 16'h0000);
        bus(0, 3'd4, 16'h0, rd, waits); chk("R1 imask", rd, 16'h0000);
        bus(0, 3'd3, 16'h0, rd, waits); chk("R1 istat", rd, 16'h0000);
    endtask

    task automatic t_standby();
        bus(1, 3'd1, 16'h0004, rd, waits);
        #1;
        chk("R6 pwr_en standby", nd_pwr_en, 1);
        chk("R6 ce_n standby", nd_ce_n, 1);
        bus(1, 3'd0, 16'h1357, rd, waits);
        chk("R4 no wait inactive", waits, 0);
        chk("R6 no write pulses", wcnt, 0);
        bus(0, 3'd0, 16'h0, rd, waits);
        chk("R6 read zero", rd, 16'h0000);
        chk("R6 no read pulses", rd_ptr, 0);
    endtask

    task automatic t_write();
        bus(1, 3'd1, 16'h000C, rd, waits);
        chk("R6 ce_n active", nd_ce_n, 0);
        bus(1, 3'd0, 16'hBEEF, rd, waits);
        chk("R4 write stall", waits, 9);
        chk("R2 pulse count", wcnt, 2);
        chk("R2 low byte first", wlog[0], {2'b00, 8'hEF});
        chk("R2 high byte second", wlog[1], {2'b00, 8'hBE});
        chk("R4 ready dropped", hst_ready, 0);
    endtask

    task automatic t_cmd_addr();
        bus(1, 3'd1, 16'h000D, rd, waits);
        bus(1, 3'd0, 16'h00FF, rd, waits);
        chk("R5 cmd byte0", wlog[2], {2'b10, 8'hFF});
        chk("R5 cmd byte1", wlog[3], {2'b10, 8'h00});
        bus(1, 3'd1, 16'h000E, rd, waits);
        bus(1, 3'd0, 16'h1234, rd, waits);
        chk("R5 addr byte0", wlog[4], {2'b01, 8'h34});
        chk("R5 addr byte1", wlog[5], {2'b01, 8'h12});
        bus(0, 3'd1, 16'h0, rd, waits);
        chk("R5 mode readback", rd, 16'h000E);
    endtask

    task automatic t_read();
        bus(1, 3'd1, 16'h000C, rd, waits);
        bus(0, 3'd0, 16'h0, rd, waits);
        chk("R3 word assembly", rd, 16'h3CA5);
        chk("R4 read stall", waits, 9);
        chk("R3 pulse count", rd_ptr, 2);
        bus(0, 3'd0, 16'h0, rd, waits);
        chk("R3 second word", rd, 16'hFE01);
        chk("R3 no extra writes", wcnt, 6);
    endtask

    task automatic t_busy_irq();
        @(negedge clk);
        nd_rb = 1'b0;
        bus(0, 3'd2, 16'h0, rd, waits);
        chk("R7 busy one edge later", rd, 16'h0000);
        bus(0, 3'd2, 16'h0, rd, waits);
        chk("R7 busy two edges later", rd, 16'h0001);
        repeat (3) @(posedge clk);
        bus(0, 3'd3, 16'h0, rd, waits);
        chk("R8 fall sets bit1", rd, 16'h0002);
        @(negedge clk);
        nd_rb = 1'b1;
        repeat (4) @(posedge clk);
        bus(0, 3'd2, 16'h0, rd, waits);
        chk("R7 ready again", rd, 16'h0000);
        bus(0, 3'd3, 16'h0, rd, waits);
        chk("R8 rise sets bit0", rd, 16'h0003);
        chk("R10 no irq mask 0", irq, 0);
        bus(1, 3'd4, 16'h0001, rd, waits);
        chk("R10 no global enable", irq, 0);
        bus(1, 3'd4, 16'h0081, rd, waits);
        chk("R10 irq on ready", irq, 1);
    endtask

    task automatic t_w1c();
        bus(1, 3'd3, 16'h0001, rd, waits);
        chk("R9 bit0 cleared irq low", irq, 0);
        bus(0, 3'd3, 16'h0, rd, waits);
        chk("R9 bit1 kept", rd, 16'h0002);
        bus(1, 3'd4, 16'h0082, rd, waits);
        chk("R10 busy source irq", irq, 1);
        bus(1, 3'd3, 16'h000F, rd, waits);
        bus(0, 3'd3, 16'h0, rd, waits);
        chk("R9 clear all", rd, 16'h0000);
        chk("R10 irq after clear", irq, 0);
        bus(1, 3'd4, 16'h0000, rd, waits);
        bus(0, 3'd4, 16'h0, rd, waits);
        chk("R10 mask disabled", rd, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            rd_mem[i] = 8'(i * 17);
            wlog[i] = 10'h0;
        end
        rd_mem[0] = 8'hA5; rd_mem[1] = 8'h3C;
        rd_mem[2] = 8'h01; rd_mem[3] = 8'hFE;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_standby();
        t_write();
        t_cmd_addr();
        t_read();
        t_busy_irq();
        t_w1c();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule